// File: doc/BRIEF.md
# Modular polynomial vector accumulator

This block builds, row by row, the modular sum t[i] = e[i] + P[i][0] + ... + P[i][K-1], where every polynomial has N coefficients of W bits and all arithmetic is modulo a prime Q. The product polynomials P[i][j] come from an upstream multiplier as a stream of coefficients, one per cycle in which the consume strobe `prod_vld` is high. They arrive in order of coefficient index first, then term j, then row i. The error polynomials sit in an internal error bank. The running results sit in an internal result bank. Both are synchronous-read memories.

For each consumed coefficient the block performs a read-modify-write. It reads the addend: the error coefficient for the first term of a row, or the running result left by the previous term for later terms. It adds the product coefficient modulo Q and writes the sum back into the result bank. The addend read is registered. It is issued one cycle ahead and always points at the index that the next strobe will consume, so the operand is ready even when strobes arrive on consecutive cycles. A `start` pulse opens a one-cycle load phase that primes the read register. The accumulate phase then follows, and `done` pulses once after the last coefficient of the last row. Every write into the result bank also appears on the `wb_*` ports.

Top module: `polyvec_acc`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `wb_vld` are all 0.
- R2: A strobe while idle, or in the single load cycle that follows the cycle in which `start` is sampled, produces no write-back. `busy` is 1 from the load cycle onward.
- R3: For the first term of row i (j = 0), the written value is (e + p) mod Q. Here p is the product coefficient and e is the error-bank word at flat address (K+i)*N + o. Error-bank slots 0..K-1 are never used as addends.
- R4: For a later term (j > 0), the written value is (t + p) mod Q, where t is the value written at the same index by term j-1 of the same row.
- R5: The modular add reduces any sum of two operands below Q into 0..Q-1 with a single subtraction of Q. A sum of exactly Q gives 0, and (Q-1)+(Q-1) gives Q-2.
- R6: Write-backs appear one per strobe on `wb_addr` = i*N + o. The index o steps up by one on each strobe and wraps to 0, after which j steps up. After j = K-1 the row i steps up.
- R7: The results are the same whether strobes come with idle cycles between them or on every cycle, including across polynomial and row boundaries.
- R8: `done` is high for exactly one cycle, in the cycle after the strobe for o = N-1, j = K-1, i = K-1. `busy` is 0 in that same cycle.
- R9: A `start` pulse while `busy` is 1 has no effect on sequencing or results.
- R10: A new run after a completed one uses only the error bank for j = 0. Result-bank contents left by the previous run do not influence the new results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when idle |
| e_we | input | 1 | Error-bank write enable (preload while idle) |
| e_waddr | input | EAW = clog2(2K)+clog2(N) | Error-bank flat write address, slot*N + index |
| e_wdata | input | W | Error-bank write data |
| prod_vld | input | 1 | Consume strobe for one product coefficient |
| prod_coef | input | W | Product coefficient, below Q |
| busy | output | 1 | Load or accumulate phase active |
| done | output | 1 | One-cycle pulse at the end of a run |
| wb_vld | output | 1 | Result-bank write this cycle |
| wb_addr | output | TAW = clog2(K)+clog2(N) | Result-bank flat address, i*N + o |
| wb_data | output | W | Value written |

## Verification
The embedded properties watch, on every cycle, that written values stay below Q, that no write-back happens outside the accumulate phase, that the index steps by one per strobe, and that `done` is a lone pulse coinciding with return to idle. They also check that a result-bank read never addresses the word being written in the same cycle, and that `busy` only rises after a `start`. Only the bench's scenarios can show the actual sums. This covers the choice of error or running source for each term, the read-old behaviour that lets j > 0 terms see the previous term's value, the equivalence of gapped and back-to-back cadences, and the independence of a second run from the first.

// File: rtl/polyvec_acc_pkg.sv
`timescale 1ns/1ps
package polyvec_acc_pkg;

   // sequencing phase of the accumulator
   typedef enum logic [1:0] {
      PVA_IDLE = 2'd0,
      PVA_LOAD = 2'd1,
      PVA_ACC  = 2'd2
   } pva_phase_e;

endpackage

// File: rtl/pva_modadd.sv
`timescale 1ns/1ps
// (a + b) mod Q for a, b < Q with a single conditional subtraction.
module pva_modadd #(
   parameter int unsigned W        = 12,
   parameter int unsigned Q        = 3329,
   parameter bit          PARALLEL = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y
);

   if (Q < 2 || Q >= (1 << W)) begin : g_bad_q
      $error("pva_modadd: Q must be in 2 .. 2**W-1");
   end

   logic [W:0] sum;
   assign sum = {1'b0, a} + {1'b0, b};

   if (PARALLEL) begin : g_par
      // subtract in parallel and choose on the borrow
      logic [W+1:0] diff;
      assign diff = {1'b0, sum} - (W+2)'(Q);
      assign y    = diff[W+1] ? sum[W-1:0] : W'(diff);
   end else begin : g_cmp
      // compare first, then subtract
      assign y = (sum >= (W+1)'(Q)) ? W'(sum - (W+1)'(Q)) : sum[W-1:0];
   end

endmodule

// File: rtl/pva_bank.sv
`timescale 1ns/1ps
// Single-write, single-read memory with a registered (read-old) output.
module pva_bank #(
   parameter  int unsigned W     = 12,
   parameter  int unsigned DEPTH = 768,
   localparam int unsigned AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("pva_bank: DEPTH must be at least 2");
   end

   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   // read register: returns the word as it was before this edge's write
   always_ff @(posedge clk) begin
      if (rst)     rdata <= '0;
      else if (re) rdata <= mem[raddr];
   end

endmodule

// File: rtl/pva_seq.sv
`timescale 1ns/1ps
// Phase control and (row, term, index) sequencing.
module pva_seq
   import polyvec_acc_pkg::*;
#(
   parameter  int unsigned K  = 3,
   parameter  int unsigned N  = 256,
   localparam int unsigned IW = $clog2(K),
   localparam int unsigned OW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic          prod_vld,
   output pva_phase_e    phase,
   output logic          take,
   output logic [IW-1:0] row_q,
   output logic [OW-1:0] idx_q,
   output logic [IW-1:0] row_n,
   output logic [IW-1:0] term_n,
   output logic [OW-1:0] idx_n,
   output logic          done
);

   pva_phase_e    phase_q;
   logic [IW-1:0] term_q;
   logic          last_idx, last_term, last_row, last_all;

   assign phase     = phase_q;
   assign take      = (phase_q == PVA_ACC) && prod_vld;
   assign last_idx  = (idx_q  == OW'(N-1));
   assign last_term = (term_q == IW'(K-1));
   assign last_row  = (row_q  == IW'(K-1));
   assign last_all  = last_idx && last_term && last_row;

   // next tuple: the position the next strobe will consume
   always_comb begin
      row_n  = row_q;
      term_n = term_q;
      idx_n  = idx_q;
      if (phase_q == PVA_IDLE) begin
         row_n  = '0;
         term_n = '0;
         idx_n  = '0;
      end else if (take) begin
         idx_n = last_idx ? '0 : idx_q + 1'b1;
         if (last_idx) begin
            if (last_term) begin
               term_n = '0;
               row_n  = last_row ? '0 : row_q + 1'b1;
            end else begin
               term_n = term_q + 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PVA_IDLE;
         row_q   <= '0;
         term_q  <= '0;
         idx_q   <= '0;
         done    <= 1'b0;
      end else begin
         row_q  <= row_n;
         term_q <= term_n;
         idx_q  <= idx_n;
         done   <= take && last_all;
         case (phase_q)
            PVA_IDLE: if (start) phase_q <= PVA_LOAD;
            PVA_LOAD: phase_q <= PVA_ACC;
            PVA_ACC:  if (take && last_all) phase_q <= PVA_IDLE;
            default:  phase_q <= PVA_IDLE;
         endcase
      end
   end

   // R6: each strobe below the last index advances the index by one
   assert_idx_step_R6: assert property (@(posedge clk) disable iff (rst)
      (take && !last_idx) |=> (idx_q == $past(idx_q) + 1'b1));

   // R8: done is a lone pulse
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R8: done coincides with the return to idle
   assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
      done |-> (phase_q == PVA_IDLE));

   // R2: the load phase lasts exactly one cycle
   assert_load_once_R2: assert property (@(posedge clk) disable iff (rst)
      (phase_q == PVA_LOAD) |=> (phase_q == PVA_ACC));

endmodule

// File: rtl/polyvec_acc.sv
`timescale 1ns/1ps
// Modular polynomial vector accumulator, top level.
module polyvec_acc
   import polyvec_acc_pkg::*;
#(
   parameter  int unsigned K             = 3,
   parameter  int unsigned N             = 256,
   parameter  int unsigned W             = 12,
   parameter  int unsigned Q             = 3329,
   parameter  bit          ADD_PARALLEL  = 1'b1,
   localparam int unsigned IW            = $clog2(K),
   localparam int unsigned OW            = $clog2(N),
   localparam int unsigned ESW           = $clog2(2*K),
   localparam int unsigned EAW           = ESW + OW,
   localparam int unsigned TAW           = IW + OW
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           start,
   input  logic           e_we,
   input  logic [EAW-1:0] e_waddr,
   input  logic [W-1:0]   e_wdata,
   input  logic           prod_vld,
   input  logic [W-1:0]   prod_coef,
   output logic           busy,
   output logic           done,
   output logic           wb_vld,
   output logic [TAW-1:0] wb_addr,
   output logic [W-1:0]   wb_data
);

   if (K < 2 || K > 4) begin : g_bad_k
      $error("polyvec_acc: K must be 2, 3 or 4");
   end
   if (N < 2 || (N & (N - 1)) != 0) begin : g_bad_n
      $error("polyvec_acc: N must be a power of two, at least 2");
   end

   pva_phase_e    phase;
   logic          take;
   logic [IW-1:0] row_q, row_n, term_n;
   logic [OW-1:0] idx_q, idx_n;

   pva_seq #(.K(K), .N(N)) seq_i (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .prod_vld (prod_vld),
      .phase    (phase),
      .take     (take),
      .row_q    (row_q),
      .idx_q    (idx_q),
      .row_n    (row_n),
      .term_n   (term_n),
      .idx_n    (idx_n),
      .done     (done)
   );

   // read-ahead addresses for the position the next strobe consumes
   logic           rd_en;
   logic [ESW-1:0] e_slot;
   logic [EAW-1:0] e_raddr;
   logic [TAW-1:0] t_raddr;
   logic           src_err_n;

   assign rd_en     = (phase != PVA_IDLE);
   assign e_slot    = ESW'(K) + ESW'(row_n);
   assign e_raddr   = {e_slot, idx_n};
   assign t_raddr   = {row_n, idx_n};
   assign src_err_n = (term_n == '0);

   logic [W-1:0] e_rdata, t_rdata;

   pva_bank #(.W(W), .DEPTH(2*K*N)) ebank_i (
      .clk   (clk),
      .rst   (rst),
      .we    (e_we),
      .waddr (e_waddr),
      .wdata (e_wdata),
      .re    (rd_en),
      .raddr (e_raddr),
      .rdata (e_rdata)
   );

   pva_bank #(.W(W), .DEPTH(K*N)) tbank_i (
      .clk   (clk),
      .rst   (rst),
      .we    (wb_vld),
      .waddr (wb_addr),
      .wdata (wb_data),
      .re    (rd_en),
      .raddr (t_raddr),
      .rdata (t_rdata)
   );

   // source select travels with the registered read
   logic src_err_q;
   always_ff @(posedge clk) begin
      if (rst)        src_err_q <= 1'b0;
      else if (rd_en) src_err_q <= src_err_n;
   end

   logic [W-1:0] addend, sum;
   assign addend = src_err_q ? e_rdata : t_rdata;

   pva_modadd #(.W(W), .Q(Q), .PARALLEL(ADD_PARALLEL)) add_i (
      .a (addend),
      .b (prod_coef),
      .y (sum)
   );

   assign busy    = rd_en;
   assign wb_vld  = take;
   assign wb_addr = {row_q, idx_q};
   assign wb_data = sum;

   // R5: every written value is reduced below Q
   assert_wb_below_q_R5: assert property (@(posedge clk) disable iff (rst)
      wb_vld |-> (wb_data < W'(Q)));

   // R2: no write-back in the load cycle or while idle
   assert_wb_after_load_R2: assert property (@(posedge clk) disable iff (rst)
      wb_vld |-> ($past(busy) && busy));

   // R4: the result-bank read never targets the word being written
   assert_read_old_R4: assert property (@(posedge clk) disable iff (rst)
      (wb_vld && !src_err_n) |-> (t_raddr != wb_addr));

   // R9: busy only rises after a start
   assert_busy_rise_R9: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> $past(start));

endmodule

// File: tb/polyvec_acc_tb_top.sv
`timescale 1ns/1ps
module polyvec_acc_tb_top;

   localparam int K   = 3;
   localparam int N   = 256;
   localparam int W   = 12;
   localparam int Q   = 3329;
   localparam int EAW = $clog2(2*K) + $clog2(N);
   localparam int TAW = $clog2(K) + $clog2(N);

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           start = 1'b0;
   logic           e_we = 1'b0;
   logic [EAW-1:0] e_waddr = '0;
   logic [W-1:0]   e_wdata = '0;
   logic           prod_vld = 1'b0;
   logic [W-1:0]   prod_coef = '0;
   logic           busy, done, wb_vld;
   logic [TAW-1:0] wb_addr;
   logic [W-1:0]   wb_data;

   always #2.5 clk = ~clk;

   polyvec_acc #(.K(K), .N(N), .W(W), .Q(Q)) dut_i (
      .clk, .rst, .start, .e_we, .e_waddr, .e_wdata,
      .prod_vld, .prod_coef, .busy, .done, .wb_vld, .wb_addr, .wb_data
   );

   typedef struct {
      int    addr;
      int    data;
      string req;
   } exp_t;

   exp_t q_exp[$];
   int   checks = 0;
   int   failures = 0;
   int   e_m [K][N];
   int   t_m [K][N];
   int   cyc = 0;
   bit   finished = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: pop and compare every write-back
   always @(negedge clk) begin
      if (!rst && wb_vld) begin
         if (q_exp.size() == 0) begin
            chk(1'b0, "R2", int'(wb_addr), -1);
         end else begin
            exp_t it;
            it = q_exp.pop_front();
            chk(int'(wb_addr) == it.addr, "R6", int'(wb_addr), it.addr);
            chk(int'(wb_data) == it.data, it.req, int'(wb_data), it.data);
         end
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=0", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic e_write(input int addr, input int data);
      @(posedge clk); #1;
      e_we = 1'b1; e_waddr = EAW'(addr); e_wdata = W'(data);
      @(posedge clk); #1;
      e_we = 1'b0;
   endtask

   task automatic load_err(input int seed);
      for (int s = 0; s < 2*K; s++) begin
         for (int o = 0; o < N; o++) begin
            if (s < K) begin
               e_write(s*N + o, Q - 1 - (o % 7));   // unused slots hold junk
            end else begin
               e_m[s-K][o] = (o*37 + s*101 + seed) % Q;
               e_write(s*N + o, e_m[s-K][o]);
            end
         end
      end
   endtask

   // mode 0: idle cycle before every pair of strobes; mode 1: back-to-back
   task automatic run_pass(input int mode, input int seed);
      int n = 0;
      @(posedge clk); #1;
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      prod_vld = 1'b1; prod_coef = W'(5);        // load cycle: ignored
      @(negedge clk);
      chk(busy == 1'b1, "R2", int'(busy), 1);
      chk(wb_vld == 1'b0, "R2", int'(wb_vld), 0);
      for (int i = 0; i < K; i++) begin
         for (int j = 0; j < K; j++) begin
            for (int o = 0; o < N; o++) begin
               int cur, p, res;
               string tag;
               exp_t it;
               cur = (j == 0) ? e_m[i][o] : t_m[i][o];
               if (o == 0)      p = (Q - cur) % Q;
               else if (o == 2) p = Q - 1;
               else             p = (o*1103 + i*331 + j*97 + seed) % Q;
               res = (cur + p) % Q;
               t_m[i][o] = res;
               if (o == 0 || o == 2) tag = "R5";
               else if (j == 0)      tag = (mode == 0) ? "R3" : "R10";
               else                  tag = (mode == 0) ? "R4" : "R7";
               if (mode == 0 && (n % 2) == 0) begin
                  @(posedge clk); #1;
                  prod_vld = 1'b0;
               end
               it.addr = i*N + o;
               it.data = res;
               it.req  = tag;
               @(posedge clk); #1;
               q_exp.push_back(it);
               prod_vld  = 1'b1;
               prod_coef = W'(p);
               start     = (mode == 1 && n == 100);  // R9: start while busy
               if (mode == 1 && n == 101) begin
                  @(negedge clk);
                  chk(busy == 1'b1, "R9", int'(busy), 1);
               end
               n++;
            end
         end
      end
      @(posedge clk); #1;
      prod_vld = 1'b0;
      start    = 1'b0;
      @(negedge clk);
      chk(done == 1'b1, "R8", int'(done), 1);
      chk(busy == 1'b0, "R8", int'(busy), 0);
      @(negedge clk);
      chk(done == 1'b0, "R8", int'(done), 0);
      chk(q_exp.size() == 0, "R6", q_exp.size(), 0);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      chk(busy == 1'b0, "R1", int'(busy), 0);
      chk(done == 1'b0, "R1", int'(done), 0);
      chk(wb_vld == 1'b0, "R1", int'(wb_vld), 0);

      load_err(17);

      // R2: strobes while idle produce nothing
      @(posedge clk); #1;
      prod_vld = 1'b1; prod_coef = W'(9);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(wb_vld == 1'b0, "R2", int'(wb_vld), 0);
      chk(busy == 1'b0, "R2", int'(busy), 0);
      @(posedge clk); #1;
      prod_vld = 1'b0;

      run_pass(0, 3);     // gapped cadence: R3, R4, R5
      load_err(901);
      run_pass(1, 211);   // back-to-back, second run: R7, R9, R10

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule